// File: doc/BRIEF.md
# Exclusive Two-Level Cache with Victim Store

This block is a small cache pair placed between a processor request port and a block-wide memory port. The first level is a direct-mapped array of lines. The second level is a small fully associative store. It is filled only with blocks pushed out of the first level, so it acts as a victim store. The two levels never hold the same block. When the second level hits, its block is swapped into the first level and is not copied. A block is fetched from memory only when both levels miss, and the fetched block goes straight into the first level.

A request carries a word address, a read or write flag and write data. The controller sits in `ST_IDLE` until a request arrives, then moves to `ST_LOOKUP`. There it probes the first level and then the second. A first-level hit or a second-level hit (a swap) finishes in `ST_LOOKUP` and returns to `ST_IDLE`. On a miss in both levels the controller goes to `ST_REFILL`. If the second level is full, the incoming victim needs room, and the oldest entry is dirty, the controller goes to `ST_EVICT` first to write that entry out, and then to `ST_REFILL`. `ST_REFILL` returns to `ST_IDLE` when memory acknowledges. Writes allocate a line and set its dirty bit. The dirty bit moves with a block between the levels.

Top module: `xc_exclusive_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, both memory requests are 0, and every line and entry is invalid, so the first access to any block misses in both levels.
- R2: A first-level hit returns its response in the second cycle after acceptance. It makes no memory request and leaves the second level unchanged.
- R3: A word address splits as follows: word offset in the low log2(WORDS) bits, first-level index in the next log2(L1_LINES) bits, tag in the rest. The block number is the address without the offset, and mem_addr carries it. Word w of a block occupies bits [w*DATA_W +: DATA_W].
- R4: On a first-level miss with a second-level hit, the block moves into the first level and its second-level entry is removed. A valid displaced first-level block enters the second level as its newest entry. The response comes with first-level-hit timing, and there is no memory traffic.
- R5: On a miss in both levels, the block is read from memory into the first level, and a valid displaced first-level block enters the second level as its newest entry.
- R6: No block number is ever valid in both levels at once.
- R7: The second level keeps entries in arrival order. When it is full and must take a victim, its oldest entry is discarded.
- R8: A discarded oldest entry that is dirty is written to memory, with its block number and data, before the read of the missed block. A clean one is dropped without any memory write.
- R9: A write sets the dirty bit of the line it lands in. A block keeps its dirty bit while moving between the levels. A block read from memory starts clean.
- R10: A read returns the addressed word. A write allocates the block on a miss, stores its word, and returns the written word.
- R11: A request is taken when req_valid and req_ready are both 1. A memory request is held with a stable address until mem_ack, read and write are never requested together, and each response lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DATA_W | Read word, or the written word for a write |
| mem_rd_req | output | 1 | Block read request |
| mem_wr_req | output | 1 | Block write request |
| mem_addr | output | ADDR_W-log2(WORDS) | Block number for the memory access |
| mem_wdata | output | DATA_W*WORDS | Block being written to memory |
| mem_rdata | input | DATA_W*WORDS | Block returned by memory, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the pending memory request |

## Verification
The bench pushes conflicting blocks through the same first-level index until the second level is full. It then makes the oldest entry dirty, so the next victim forces a write-back. A design that copied instead of swapping would return stale data once the old copy came back into use. A design that discarded the newest entry, or dropped a dirty block without writing it, would show a wrong or missing memory write and later a wrong read. A long stream of mixed reads and writes over a small set of blocks checks swap timing, dirty propagation through repeated swaps, and the order of write-back before fetch, all against a queue-based model. A design that sent hits to memory, or lost the dirty bit on a swap, would differ in latency or in the traffic the model predicts.

// File: rtl/xc_pkg.sv
package xc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_REFILL
    } xc_state_t;

endpackage

// File: rtl/xc_l1_store.sv
module xc_l1_store #(
    parameter int LINES = 4,
    parameter int IDX_W = $clog2(LINES),
    parameter int TAG_W = 4,
    parameter int BLK_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         idx,
    output logic                     rd_vld,
    output logic                     rd_dirty,
    output logic [TAG_W-1:0]         rd_tag,
    output logic [BLK_W-1:0]         rd_data,
    input  logic                     we,
    input  logic [TAG_W-1:0]         wtag,
    input  logic                     wdirty,
    input  logic [BLK_W-1:0]         wdata,
    output logic [LINES-1:0]         all_vld,
    output logic [LINES*TAG_W-1:0]   all_tag
);

    logic [LINES-1:0]  vld_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [BLK_W-1:0]  data_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            dirty_q <= '0;
        end else if (we) begin
            vld_q[idx]   <= 1'b1;
            dirty_q[idx] <= wdirty;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[idx]  <= wtag;
            data_q[idx] <= wdata;
        end
    end

    assign rd_vld   = vld_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_data  = data_q[idx];
    assign all_vld  = vld_q;

    for (genvar g = 0; g < LINES; g++) begin : g_flat
        assign all_tag[g*TAG_W +: TAG_W] = tag_q[g];
    end

endmodule

// File: rtl/xc_l2_fifo.sv
module xc_l2_fifo #(
    parameter int ENTRIES = 4,
    parameter int BN_W    = 6,
    parameter int BLK_W   = 32,
    parameter int POS_W   = $clog2(ENTRIES),
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BN_W-1:0]           key,
    output logic                      hit,
    output logic [POS_W-1:0]          hit_pos,
    output logic                      hit_dirty,
    output logic [BLK_W-1:0]          hit_data,
    output logic                      full,
    output logic [BN_W-1:0]           head_bn,
    output logic                      head_dirty,
    output logic [BLK_W-1:0]          head_data,
    input  logic                      rm_en,
    input  logic [POS_W-1:0]          rm_pos,
    input  logic                      push_en,
    input  logic [BN_W-1:0]           push_bn,
    input  logic                      push_dirty,
    input  logic [BLK_W-1:0]          push_data,
    output logic [ENTRIES*BN_W-1:0]   all_bn,
    output logic [CNT_W-1:0]          count
);

    logic [BN_W-1:0]   bn_q    [ENTRIES];
    logic              dirty_q [ENTRIES];
    logic [BLK_W-1:0]  data_q  [ENTRIES];
    logic [CNT_W-1:0]  count_q;

    logic [BN_W-1:0]   bn_d    [ENTRIES];
    logic              dirty_d [ENTRIES];
    logic [BLK_W-1:0]  data_d  [ENTRIES];
    logic [CNT_W-1:0]  cnt_mid;
    logic [CNT_W-1:0]  count_d;

    // associative search over the occupied part of the queue
    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (CNT_W'(i) < count_q && bn_q[i] == key) begin
                hit     = 1'b1;
                hit_pos = POS_W'(i);
            end
        end
    end

    assign hit_dirty  = dirty_q[hit_pos];
    assign hit_data   = data_q[hit_pos];
    assign full       = (count_q == CNT_W'(ENTRIES));
    assign head_bn    = bn_q[0];
    assign head_dirty = dirty_q[0];
    assign head_data  = data_q[0];
    assign count      = count_q;

    // removal closes the gap, then an arrival joins at the tail
    always_comb begin
        bn_d    = bn_q;
        dirty_d = dirty_q;
        data_d  = data_q;
        cnt_mid = count_q;
        if (rm_en) begin
            for (int i = 0; i < ENTRIES - 1; i++) begin
                if (POS_W'(i) >= rm_pos) begin
                    bn_d[i]    = bn_q[i+1];
                    dirty_d[i] = dirty_q[i+1];
                    data_d[i]  = data_q[i+1];
                end
            end
            cnt_mid = count_q - CNT_W'(1);
        end
        if (push_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (CNT_W'(i) == cnt_mid) begin
                    bn_d[i]    = push_bn;
                    dirty_d[i] = push_dirty;
                    data_d[i]  = push_data;
                end
            end
        end
        count_d = cnt_mid + CNT_W'(push_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        bn_q    <= bn_d;
        dirty_q <= dirty_d;
        data_q  <= data_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign all_bn[g*BN_W +: BN_W] = bn_q[g];
    end

endmodule

// File: rtl/xc_exclusive_cache.sv
module xc_exclusive_cache
    import xc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int WORDS      = 4,
    parameter int ADDR_W     = 8,
    parameter int L1_LINES   = 4,
    parameter int L2_ENTRIES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic                                   req_write,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    output logic                                   resp_valid,
    output logic [DATA_W-1:0]                      resp_rdata,
    output logic                                   mem_rd_req,
    output logic                                   mem_wr_req,
    output logic [ADDR_W-$clog2(WORDS)-1:0]        mem_addr,
    output logic [DATA_W*WORDS-1:0]                mem_wdata,
    input  logic [DATA_W*WORDS-1:0]                mem_rdata,
    input  logic                                   mem_ack
);

    localparam int OFF_W = $clog2(WORDS);
    localparam int BLK_W = DATA_W * WORDS;
    localparam int BN_W  = ADDR_W - OFF_W;
    localparam int IDX_W = $clog2(L1_LINES);
    localparam int TAG_W = BN_W - IDX_W;
    localparam int POS_W = $clog2(L2_ENTRIES);
    localparam int CNT_W = $clog2(L2_ENTRIES + 1);

    xc_state_t state_q, state_d;

    logic               q_write;
    logic [BN_W-1:0]    q_bn;
    logic [OFF_W-1:0]   q_off;
    logic [DATA_W-1:0]  q_wdata;
    logic [IDX_W-1:0]   q_idx;
    logic [TAG_W-1:0]   q_tag;

    logic               l1_vld, l1_dirty, l1_we, l1_wdirty, l1_hit;
    logic [TAG_W-1:0]   l1_tag;
    logic [BLK_W-1:0]   l1_data, l1_wdata;
    logic [L1_LINES-1:0]        l1_all_vld;
    logic [L1_LINES*TAG_W-1:0]  l1_all_tag;

    logic               l2_hit, l2_hit_dirty, l2_full, l2_head_dirty;
    logic [POS_W-1:0]   l2_hit_pos, rm_pos;
    logic [BLK_W-1:0]   l2_hit_data, l2_head_data;
    logic [BN_W-1:0]    l2_head_bn;
    logic               rm_en, push_en;
    logic [L2_ENTRIES*BN_W-1:0] l2_all_bn;
    logic [CNT_W-1:0]   l2_count;

    logic               need_room, finish, base_dirty;
    logic [BLK_W-1:0]   base_data;
    logic [DATA_W-1:0]  out_word;

    assign q_idx     = q_bn[IDX_W-1:0];
    assign q_tag     = q_bn[BN_W-1:IDX_W];
    assign l1_hit    = l1_vld && (l1_tag == q_tag);
    assign need_room = l1_vld && l2_full;

    xc_l1_store #(
        .LINES (L1_LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .BLK_W (BLK_W)
    ) u_l1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (q_idx),
        .rd_vld   (l1_vld),
        .rd_dirty (l1_dirty),
        .rd_tag   (l1_tag),
        .rd_data  (l1_data),
        .we       (l1_we),
        .wtag     (q_tag),
        .wdirty   (l1_wdirty),
        .wdata    (l1_wdata),
        .all_vld  (l1_all_vld),
        .all_tag  (l1_all_tag)
    );

    xc_l2_fifo #(
        .ENTRIES (L2_ENTRIES),
        .BN_W    (BN_W),
        .BLK_W   (BLK_W),
        .POS_W   (POS_W),
        .CNT_W   (CNT_W)
    ) u_l2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .key        (q_bn),
        .hit        (l2_hit),
        .hit_pos    (l2_hit_pos),
        .hit_dirty  (l2_hit_dirty),
        .hit_data   (l2_hit_data),
        .full       (l2_full),
        .head_bn    (l2_head_bn),
        .head_dirty (l2_head_dirty),
        .head_data  (l2_head_data),
        .rm_en      (rm_en),
        .rm_pos     (rm_pos),
        .push_en    (push_en),
        .push_bn    ({l1_tag, q_idx}),
        .push_dirty (l1_dirty),
        .push_data  (l1_data),
        .all_bn     (l2_all_bn),
        .count      (l2_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (l1_hit || l2_hit)              state_d = ST_IDLE;
                else if (need_room && l2_head_dirty) state_d = ST_EVICT;
                else                               state_d = ST_REFILL;
            end
            ST_EVICT:  if (mem_ack) state_d = ST_REFILL;
            ST_REFILL: if (mem_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath strobes
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_wr_req = 1'b0;
        mem_rd_req = 1'b0;
        mem_addr   = q_bn;
        mem_wdata  = l2_head_data;
        finish     = 1'b0;
        l1_we      = 1'b0;
        rm_en      = 1'b0;
        rm_pos     = '0;
        push_en    = 1'b0;
        base_data  = l1_data;
        base_dirty = l1_dirty;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOOKUP: begin
                if (l1_hit) begin
                    finish = 1'b1;
                    l1_we  = q_write;
                end else if (l2_hit) begin
                    finish     = 1'b1;
                    base_data  = l2_hit_data;
                    base_dirty = l2_hit_dirty;
                    l1_we      = 1'b1;
                    rm_en      = 1'b1;
                    rm_pos     = l2_hit_pos;
                    push_en    = l1_vld;
                end
            end
            ST_EVICT: begin
                mem_wr_req = 1'b1;
                mem_addr   = l2_head_bn;
            end
            ST_REFILL: begin
                mem_rd_req = 1'b1;
                if (mem_ack) begin
                    finish     = 1'b1;
                    base_data  = mem_rdata;
                    base_dirty = 1'b0;
                    l1_we      = 1'b1;
                    rm_en      = need_room;
                    push_en    = l1_vld;
                end
            end
            default: ;
        endcase
        l1_wdata  = base_data;
        out_word  = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (OFF_W'(w) == q_off) begin
                if (q_write) l1_wdata[w*DATA_W +: DATA_W] = q_wdata;
                out_word = l1_wdata[w*DATA_W +: DATA_W];
            end
        end
        l1_wdirty = base_dirty | q_write;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_bn    <= '0;
            q_off   <= '0;
            q_wdata <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            q_write <= req_write;
            q_bn    <= req_addr[ADDR_W-1:OFF_W];
            q_off   <= req_addr[OFF_W-1:0];
            q_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= finish;
            if (finish) resp_rdata <= out_word;
        end
    end

endmodule

// File: rtl/xc_exclusive_cache_checker.sv
module xc_exclusive_cache_checker
    import xc_pkg::*;
#(
    parameter int L1_LINES   = 4,
    parameter int L2_ENTRIES = 4,
    parameter int IDX_W      = 2,
    parameter int TAG_W      = 4,
    parameter int BN_W       = 6,
    parameter int CNT_W      = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  xc_state_t                     state_q,
    input  logic                          l1_hit,
    input  logic                          l1_vld,
    input  logic                          l2_hit,
    input  logic [L1_LINES-1:0]           l1_all_vld,
    input  logic [L1_LINES*TAG_W-1:0]     l1_all_tag,
    input  logic [L2_ENTRIES*BN_W-1:0]    l2_all_bn,
    input  logic [CNT_W-1:0]              l2_count,
    input  logic                          mem_rd_req,
    input  logic                          mem_wr_req,
    input  logic [BN_W-1:0]               mem_addr,
    input  logic                          mem_ack,
    input  logic                          resp_valid
);

    logic overlap;

    always_comb begin
        overlap = 1'b0;
        for (int i = 0; i < L1_LINES; i++) begin
            for (int j = 0; j < L2_ENTRIES; j++) begin
                if (l1_all_vld[i] && CNT_W'(j) < l2_count &&
                    {l1_all_tag[i*TAG_W +: TAG_W], IDX_W'(i)} == l2_all_bn[j*BN_W +: BN_W])
                    overlap = 1'b1;
            end
        end
    end

    a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !overlap);

    a_r2_l2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && l1_hit) |=> ($stable(l2_count) && $stable(l2_all_bn)));

    a_r2_no_mem_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && l1_hit) |=> (!mem_rd_req && !mem_wr_req));

    a_r4_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !l1_hit && l2_hit && l1_vld) |=> $stable(l2_count));

    a_r7_l2_bound: assert property (@(posedge clk) disable iff (!rst_n)
        l2_count <= CNT_W'(L2_ENTRIES));

    a_r11_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    a_r11_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_addr)));

    a_r11_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_addr)));

    a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

endmodule

bind xc_exclusive_cache xc_exclusive_cache_checker #(
    .L1_LINES   (L1_LINES),
    .L2_ENTRIES (L2_ENTRIES),
    .IDX_W      (IDX_W),
    .TAG_W      (TAG_W),
    .BN_W       (BN_W),
    .CNT_W      (CNT_W)
) u_xc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .l1_hit     (l1_hit),
    .l1_vld     (l1_vld),
    .l2_hit     (l2_hit),
    .l1_all_vld (l1_all_vld),
    .l1_all_tag (l1_all_tag),
    .l2_all_bn  (l2_all_bn),
    .l2_count   (l2_count),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .resp_valid (resp_valid)
);

// File: tb/xc_exclusive_cache_bench.sv
`timescale 1ns/1ps
module xc_exclusive_cache_bench;

    localparam int DATA_W = 8, WORDS = 4, ADDR_W = 8, L1_LINES = 4, L2_ENTRIES = 4;
    localparam int BLK_W = DATA_W * WORDS;
    localparam int BN_W  = 6;
    localparam int NBLK  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, resp_valid, mem_rd_req, mem_wr_req;
    logic [DATA_W-1:0] resp_rdata;
    logic [BN_W-1:0] mem_addr;
    logic [BLK_W-1:0] mem_wdata;
    logic [BLK_W-1:0] mem_rdata = '0;
    logic mem_ack = 1'b0;

    always #4 clk = ~clk;

    xc_exclusive_cache #(
        .DATA_W (DATA_W), .WORDS (WORDS), .ADDR_W (ADDR_W),
        .L1_LINES (L1_LINES), .L2_ENTRIES (L2_ENTRIES)
    ) u_xc_exclusive_cache (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
        .resp_valid (resp_valid), .resp_rdata (resp_rdata),
        .mem_rd_req (mem_rd_req), .mem_wr_req (mem_wr_req), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_ack (mem_ack)
    );

    int checks = 0;
    int fails  = 0;
    bit expect_resp = 1'b0;
    bit finished = 1'b0;

    typedef struct { int bn; bit dirty; logic [BLK_W-1:0] data; } ent_t;
    typedef struct { bit wr; int bn; logic [BLK_W-1:0] data; } memop_t;

    logic [BLK_W-1:0] phys [NBLK];
    logic [BLK_W-1:0] mdl_mem [NBLK];
    bit               l1v   [L1_LINES];
    int               l1tag [L1_LINES];
    bit               l1d   [L1_LINES];
    logic [BLK_W-1:0] l1dat [L1_LINES];
    ent_t   l2q[$];
    memop_t seen_ops[$];
    memop_t exp_ops[$];
    int nresp = 0;

    function automatic logic [BLK_W-1:0] init_blk(int bn);
        logic [BLK_W-1:0] b;
        for (int w = 0; w < WORDS; w++) b[w*DATA_W +: DATA_W] = DATA_W'(bn * 7 + w * 3 + 1);
        return b;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder: logs every request, answers after 1..3 cycles
    initial begin
        for (int b = 0; b < NBLK; b++) phys[b] = init_blk(b);
        forever begin
            @(negedge clk);
            if (rst_n && (mem_rd_req || mem_wr_req)) begin
                memop_t op;
                op.wr   = mem_wr_req;
                op.bn   = int'(mem_addr);
                op.data = mem_wr_req ? mem_wdata : '0;
                seen_ops.push_back(op);
                repeat (1 + nresp % 3) @(negedge clk);
                nresp++;
                if (op.wr) phys[op.bn] = op.data;
                else       mem_rdata = phys[op.bn];
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // per-clock comparison of port behaviour
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(!(mem_rd_req && mem_wr_req), "R11", "read and write together", 1, 0);
            check(!resp_valid || expect_resp, "R2", "unexpected response", resp_valid, 0);
        end
    end

    // behavioural model: predicts memory traffic, data and hit timing
    task automatic predict(bit wr, int addr, logic [DATA_W-1:0] wd,
                           output logic [DATA_W-1:0] exp_rd, output bit fast);
        int bn, off, idx, tag, k;
        ent_t e, vic;
        memop_t op;
        bn  = addr / WORDS;
        off = addr % WORDS;
        idx = bn % L1_LINES;
        tag = bn / L1_LINES;
        vic.bn = l1tag[idx] * L1_LINES + idx;
        vic.dirty = l1d[idx];
        vic.data = l1dat[idx];
        exp_ops.delete();
        fast = 1'b1;
        if (!(l1v[idx] && l1tag[idx] == tag)) begin
            k = -1;
            foreach (l2q[i]) if (l2q[i].bn == bn) k = i;
            if (k >= 0) begin
                e = l2q[k];
                l2q.delete(k);
                if (l1v[idx]) l2q.push_back(vic);
            end else begin
                fast = 1'b0;
                if (l1v[idx] && l2q.size() == L2_ENTRIES) begin
                    e = l2q.pop_front();
                    if (e.dirty) begin
                        op.wr = 1'b1; op.bn = e.bn; op.data = e.data;
                        exp_ops.push_back(op);
                        mdl_mem[e.bn] = e.data;
                    end
                end
                op.wr = 1'b0; op.bn = bn; op.data = '0;
                exp_ops.push_back(op);
                if (l1v[idx]) l2q.push_back(vic);
                e.bn = bn; e.dirty = 1'b0; e.data = mdl_mem[bn];
            end
            l1v[idx] = 1'b1; l1tag[idx] = tag; l1d[idx] = e.dirty; l1dat[idx] = e.data;
        end
        if (wr) begin
            l1dat[idx][off*DATA_W +: DATA_W] = wd;
            l1d[idx] = 1'b1;
        end
        exp_rd = l1dat[idx][off*DATA_W +: DATA_W];
        // model-side exclusivity, R6
        foreach (l2q[i]) begin
            int ix;
            ix = l2q[i].bn % L1_LINES;
            if (l1v[ix] && l1tag[ix] == l2q[i].bn / L1_LINES)
                check(1'b0, "R6", "model overlap", l2q[i].bn, -1);
        end
    endtask

    task automatic access(bit wr, int addr, logic [DATA_W-1:0] wd, string req);
        logic [DATA_W-1:0] exp_rd;
        bit fast;
        int lat;
        predict(wr, addr, wd, exp_rd, fast);
        seen_ops.delete();
        check(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr); req_wdata = wd;
        expect_resp = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check(resp_valid == 1'b1, req, "response present", resp_valid, 1);
        check(resp_rdata == exp_rd, req, "response word (R10)", resp_rdata, exp_rd);
        if (fast) check(lat == 2, req, "hit latency (R2/R4)", lat, 2);
        else      check(lat > 2, req, "miss latency (R5)", lat, 3);
        check(seen_ops.size() == exp_ops.size(), req, "memory op count (R8)",
              seen_ops.size(), exp_ops.size());
        if (seen_ops.size() == exp_ops.size()) begin
            foreach (exp_ops[i]) begin
                check(seen_ops[i].wr == exp_ops[i].wr, req, "memory op kind (R8)",
                      seen_ops[i].wr, exp_ops[i].wr);
                check(seen_ops[i].bn == exp_ops[i].bn, req, "memory block number (R3)",
                      seen_ops[i].bn, exp_ops[i].bn);
                check(seen_ops[i].data == exp_ops[i].data, req, "write-back data (R9)",
                      seen_ops[i].data, exp_ops[i].data);
            end
        end
        @(negedge clk);
        expect_resp = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int b = 0; b < NBLK; b++) mdl_mem[b] = init_blk(b);
        for (int i = 0; i < L1_LINES; i++) begin
            l1v[i] = 1'b0; l1tag[i] = 0; l1d[i] = 1'b0; l1dat[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "no response after reset", resp_valid, 0);
        check(!mem_rd_req && !mem_wr_req, "R1", "no memory request after reset",
              {mem_rd_req, mem_wr_req}, 0);

        // R1/R5: first touch misses both levels; block 0, word 2
        access(1'b0, 0 * WORDS + 2, 8'h00, "R5");
        // R2: hit in first level
        access(1'b0, 0 * WORDS + 1, 8'h00, "R2");
        // R9/R10: write hit marks block 0 dirty
        access(1'b1, 0 * WORDS + 1, 8'hA5, "R9");
        // R5: block 4 shares index 0, block 0 moves to second level
        access(1'b0, 4 * WORDS + 0, 8'h00, "R5");
        // R4/R6: swap back block 0 with its dirty word
        access(1'b0, 0 * WORDS + 1, 8'h00, "R4");
        // R3: a different index and tag
        access(1'b1, 13 * WORDS + 3, 8'h3C, "R3");
        // fill the second level through index 0: 8,12,16,20
        access(1'b0, 8 * WORDS, 8'h00, "R7");
        access(1'b0, 12 * WORDS, 8'h00, "R7");
        access(1'b0, 16 * WORDS, 8'h00, "R7");
        access(1'b0, 20 * WORDS, 8'h00, "R7");
        // R7/R8: full second level, oldest (dirty block 0) must be written back
        access(1'b0, 24 * WORDS + 3, 8'h00, "R8");
        // R8: block 0 re-read from memory holds the written word
        access(1'b0, 0 * WORDS + 1, 8'h00, "R8");
        // R8: clean oldest dropped without a write
        access(1'b0, 28 * WORDS, 8'h00, "R8");
        // R6: swap after long chain must not revive a stale copy
        access(1'b1, 20 * WORDS + 2, 8'h77, "R6");
        access(1'b0, 28 * WORDS + 2, 8'h00, "R6");
        access(1'b0, 20 * WORDS + 2, 8'h00, "R6");

        // mixed stream over a small block range
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            int bn;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bn = int'(lfsr[4:0]) % 24;
            access(lfsr[7:6] == 2'b11, bn * WORDS + int'(lfsr[9:8]), lfsr[15:8], "R10");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule